// File: doc/BRIEF.md
# Serial SAR Converter Read Controller

This block is the host side of a link to a 12-bit successive-approximation converter with a three-wire serial port. A one-cycle `start` request makes the controller drive the active-low select line low. That select edge starts a conversion. The controller then holds the serial clock low until the conversion has ended. It learns that the conversion is over in one of two ways: it sees the data line rise, or it waits a fixed number of cycles long enough for the slowest conversion.

Once the conversion is over, the controller makes the serial clock bursts itself. It idles the clock low and samples the data on each rising edge. It can run one unbroken burst of 13 clocks, or two bursts of 8 clocks with a short pause between them. In both cases it drops the leading framing bit, and in the two-burst case it also drops the three padding bits. The 12-bit result comes out with a one-cycle `valid` strobe. It then raises the select line and keeps it high for a minimum gap before it accepts the next request. The gap is longer after an aborted or timed-out conversion so the input can settle again.

The clock half-period, the conversion wait, the edge-detect timeout and both select-high gaps are parameters counted in system clock cycles.

Top module: `sar_read_ctrl`

## Requirements
- R1: While `rst_n` is low, `cs_n` is 1, `sclk` is 0, and `valid`, `frame_err`, `eoc_timeout` and `busy` are all 0.
- R2: A `start` pulse in idle pulls `cs_n` low and starts a conversion. `sclk` stays 0 until the end of conversion is known. With `eoc_edge`=0, the first `sclk` rise comes no earlier than CONV_WAIT cycles after `cs_n` falls.
- R3: With `eoc_edge`=1, a rising edge on `miso` starts the clocking without waiting CONV_WAIT. If no rise arrives, `eoc_timeout` pulses for one cycle exactly EOC_LIMIT cycles after `cs_n` fell, `cs_n` goes back to 1, and no `valid` is given.
- R4: `sclk` idles low. Every high and low phase lasts at least HALF cycles. `miso` is sampled on each `sclk` rising edge.
- R5: With `byte_mode`=0, a read uses exactly 13 `sclk` clocks. `result` is the bits taken on rises 2 to 13, with the first of them as bit 11.
- R6: With `byte_mode`=1, a read uses exactly 16 `sclk` clocks, sent as two groups of 8. `result` is the bits taken on rises 2 to 13, with the first as bit 11. The bits taken on rises 14 to 16 are discarded.
- R7: With `byte_mode`=1, `frame_err` is 1 together with `valid` when the bit taken on the first rise is 0, and 0 when it is 1. With `byte_mode`=0, `frame_err` is 0.
- R8: `cs_n` rises in the same cycle as the last `sclk` falling edge of a read. `valid` is high for exactly one cycle, in that cycle. `result` and `frame_err` hold until the next `valid`.
- R9: After a completed read, `cs_n` stays high for at least CS_HIGH_MIN cycles before it falls again.
- R10: `abort` while a conversion is pending raises `cs_n` at once and gives no `valid`. `cs_n` then stays high for at least ACQ_MIN cycles. The same ACQ_MIN gap follows an `eoc_timeout`.
- R11: `start` has no effect while `busy` is 1. A read produces one `cs_n` fall and one `valid`, however often `start` is pulsed during it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one read (acted on only when idle) |
| byte_mode | input | 1 | 1: two 8-clock bursts, 0: one 13-clock burst |
| eoc_edge | input | 1 | 1: wait for a data-line rise, 0: wait CONV_WAIT cycles |
| abort | input | 1 | Cancel a pending conversion |
| miso | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low converter select |
| sclk | output | 1 | Serial clock, idles low |
| result | output | 12 | Last 12-bit sample |
| valid | output | 1 | One-cycle strobe for a new `result` |
| frame_err | output | 1 | Leading bit missing in two-burst mode |
| eoc_timeout | output | 1 | One-cycle pulse when the data line never rose |
| busy | output | 1 | Controller is not idle |

## Verification
The assertions assume that `miso` only changes while `sclk` is low and has settled before the next rise, which is what a converter does when it shifts on falling edges. They also assume that `start` and `abort` are synchronous to `clk`. The bench converter model meets this by changing `miso` half a system cycle after each `sclk` fall it sees, and HALF is at least 2. All stimulus is driven on the falling edge of the system clock, and the model's end-of-conversion delay is always shorter than CONV_WAIT in timed mode and shorter than EOC_LIMIT in edge mode, except in the tests that deliberately leave the data line low.

// File: rtl/sar_read_ctrl.sv
module sar_read_ctrl #(
  parameter int HALF        = 60,
  parameter int CONV_WAIT   = 1900,
  parameter int EOC_LIMIT   = 2500,
  parameter int CS_HIGH_MIN = 60,
  parameter int ACQ_MIN     = 375
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        byte_mode,
  input  logic        eoc_edge,
  input  logic        abort,
  input  logic        miso,
  output logic        cs_n,
  output logic        sclk,
  output logic [11:0] result,
  output logic        valid,
  output logic        frame_err,
  output logic        eoc_timeout,
  output logic        busy
);

  localparam int T1 = (CONV_WAIT > EOC_LIMIT) ? CONV_WAIT : EOC_LIMIT;
  localparam int T2 = (CS_HIGH_MIN > ACQ_MIN) ? CS_HIGH_MIN : ACQ_MIN;
  localparam int T3 = (T1 > T2) ? T1 : T2;
  localparam int TA = (T3 > 2 * HALF) ? T3 : 2 * HALF;
  localparam int CW = $clog2(TA + 1);
  localparam int HW = $clog2(HALF + 1);
  localparam int GW = $clog2(T2 + 1);

  typedef enum logic [2:0] {S_IDLE, S_CONV, S_SHIFT, S_PAUSE, S_GAP} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [HW-1:0] pc;
  logic [4:0]   nfall;
  logic [15:0]  sh;
  logic [2:0]   sync;
  logic         cs_q, sclk_q, byte_q, edge_q, long_q;
  logic [11:0]  result_q;
  logic         valid_q, ferr_q, tmo_q;
  logic         m_rise, last_fall;

  assign m_rise    = sync[1] & ~sync[2];
  assign last_fall = byte_q ? (nfall == 5'd15) : (nfall == 5'd12);

  assign cs_n        = cs_q;
  assign sclk        = sclk_q;
  assign result      = result_q;
  assign valid       = valid_q;
  assign frame_err   = ferr_q;
  assign eoc_timeout = tmo_q;
  assign busy        = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      pc       <= '0;
      nfall    <= '0;
      sh       <= '0;
      sync     <= '0;
      cs_q     <= 1'b1;
      sclk_q   <= 1'b0;
      byte_q   <= 1'b0;
      edge_q   <= 1'b0;
      long_q   <= 1'b0;
      result_q <= '0;
      valid_q  <= 1'b0;
      ferr_q   <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      tmo_q   <= 1'b0;
      sync    <= {sync[1:0], miso};
      case (st)
        S_IDLE: if (start) begin
          cs_q   <= 1'b0;
          cnt    <= '0;
          byte_q <= byte_mode;
          edge_q <= eoc_edge;
          st     <= S_CONV;
        end
        S_CONV: begin
          if (abort) begin
            cs_q   <= 1'b1;
            cnt    <= CW'(ACQ_MIN);
            long_q <= 1'b1;
            st     <= S_GAP;
          end else if (edge_q && m_rise) begin
            pc    <= '0;
            nfall <= '0;
            st    <= S_SHIFT;
          end else if (edge_q && cnt == CW'(EOC_LIMIT - 1)) begin
            tmo_q  <= 1'b1;
            cs_q   <= 1'b1;
            cnt    <= CW'(ACQ_MIN);
            long_q <= 1'b1;
            st     <= S_GAP;
          end else if (!edge_q && cnt == CW'(CONV_WAIT - 1)) begin
            pc    <= '0;
            nfall <= '0;
            st    <= S_SHIFT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_SHIFT: begin
          if (pc == HW'(HALF - 1)) begin
            pc     <= '0;
            sclk_q <= ~sclk_q;
            if (!sclk_q) begin
              sh <= {sh[14:0], miso};
            end else begin
              nfall <= nfall + 1'b1;
              if (last_fall) begin
                cs_q     <= 1'b1;
                valid_q  <= 1'b1;
                result_q <= byte_q ? sh[14:3] : sh[11:0];
                ferr_q   <= byte_q & ~sh[15];
                cnt      <= CW'(CS_HIGH_MIN);
                long_q   <= 1'b0;
                st       <= S_GAP;
              end else if (byte_q && nfall == 5'd7) begin
                cnt <= CW'(2 * HALF);
                st  <= S_PAUSE;
              end
            end
          end else begin
            pc <= pc + 1'b1;
          end
        end
        S_PAUSE: if (cnt <= CW'(1)) begin
          pc <= '0;
          st <= S_SHIFT;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_GAP: if (cnt <= CW'(1)) st <= S_IDLE;
               else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [GW-1:0] hi_cnt;
  logic [HW-1:0] ph_cnt;
  logic          sclk_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt <= GW'(T2);
      ph_cnt <= HW'(HALF);
      sclk_d <= 1'b0;
    end else begin
      sclk_d <= sclk_q;
      if (!cs_q) hi_cnt <= '0;
      else if (hi_cnt != GW'(T2)) hi_cnt <= hi_cnt + 1'b1;
      if (sclk_d != sclk_q) ph_cnt <= '0;
      else if (ph_cnt != HW'(HALF)) ph_cnt <= ph_cnt + 1'b1;
    end
  end

  // R2
  conv_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CONV) |-> !sclk_q);
  // R4
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> !sclk_q);
  // R4
  sclk_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk_q) || $fell(sclk_q)) |-> (ph_cnt >= HW'(HALF - 1)));
  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  // R8
  valid_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (cs_q && $rose(cs_q)));
  // R3
  timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q |-> (cs_q && !valid_q));
  // R9
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_q) |-> (hi_cnt >= GW'(CS_HIGH_MIN)));
  // R10
  acq_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_q) && long_q) |-> (hi_cnt >= GW'(ACQ_MIN)));
  // R11
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_q) |-> ($past(start) && $past(st == S_IDLE)));

endmodule

// File: tb/sar_read_ctrl_tb.sv
module sar_read_ctrl_tb;
  localparam int HALF = 2, CONV_WAIT = 40, EOC_LIMIT = 60, CS_HIGH_MIN = 5, ACQ_MIN = 9;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, byte_mode = 1'b0, eoc_edge = 1'b0, abort = 1'b0;
  logic miso = 1'b0;
  logic cs_n, sclk, valid, frame_err, eoc_timeout, busy;
  logic [11:0] result;

  always #2 clk = ~clk;

  sar_read_ctrl #(.HALF(HALF), .CONV_WAIT(CONV_WAIT), .EOC_LIMIT(EOC_LIMIT),
    .CS_HIGH_MIN(CS_HIGH_MIN), .ACQ_MIN(ACQ_MIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_mode(byte_mode), .eoc_edge(eoc_edge),
    .abort(abort), .miso(miso), .cs_n(cs_n), .sclk(sclk), .result(result), .valid(valid),
    .frame_err(frame_err), .eoc_timeout(eoc_timeout), .busy(busy));

  int checks = 0, failures = 0;
  logic [11:0] m_code = '0;
  int m_delay = 0;
  bit m_eoc = 1'b0;
  int cyc = 0, mcnt = 0, fk = 0;
  int fall_cyc = 0, rise_cyc = 0, last_gap = 0, rises = 0, first_rise = -1;
  int last_edge = 0, min_phase = 1000, n_valid = 0, n_tmo = 0, n_fall = 0, vwide = 0, tmo_gap = 0;
  int vbad = 0;
  logic [11:0] got_res = '0;
  bit got_ferr = 1'b0;
  logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_valid = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_cs && !cs_n) begin
        last_gap = cyc - rise_cyc; fall_cyc = cyc; rises = 0; first_rise = -1;
        n_fall++; mcnt = 0; fk = 0; miso <= 1'b0;
      end else if (!cs_n) begin
        mcnt++;
        if (m_eoc && mcnt == m_delay) miso <= 1'b1;
        if (prev_sclk && !sclk) begin
          fk++;
          miso <= (fk <= 12) ? m_code[12 - fk] : 1'b0;
        end
      end else begin
        miso <= 1'b0;
      end
      if (!prev_cs && cs_n) rise_cyc = cyc;
      if (!prev_sclk && sclk) begin
        rises++;
        if (first_rise < 0) first_rise = cyc - fall_cyc;
      end
      if (prev_sclk != sclk) begin
        if (cyc - last_edge < min_phase) min_phase = cyc - last_edge;
        last_edge = cyc;
      end
      if (valid) begin
        n_valid++;
        if (prev_valid) vwide++;
        if (!cs_n || sclk) vbad++;
        got_res = result; got_ferr = frame_err;
      end
      if (eoc_timeout) begin n_tmo++; tmo_gap = cyc - fall_cyc; end
    end
    prev_cs = cs_n; prev_sclk = sclk; prev_valid = valid;
  end

  task automatic run_read(input bit bm, input bit em, input logic [11:0] c, input int d, input bit e);
    int v0, t0;
    @(negedge clk);
    m_code = c; m_delay = d; m_eoc = e; byte_mode = bm; eoc_edge = em;
    v0 = n_valid; t0 = n_tmo;
    start = 1'b1;
    for (int i = 0; i < 200 && cs_n; i++) @(negedge clk);
    start = 1'b0;
    min_phase = 1000;
    for (int i = 0; i < 500 && n_valid == v0 && n_tmo == t0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int v0, f0, t0;
    logic [11:0] code;
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0, "R1 reset cs_n/sclk", {cs_n, sclk}, 2);
    chk({valid, frame_err, eoc_timeout, busy} === 4'b0, "R1 reset flags",
        {valid, frame_err, eoc_timeout, busy}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // sweep: every mode combination over a set of codes
    for (int md = 0; md < 4; md++) begin
      for (int k = 0; k < 16; k++) begin
        code = (k == 0) ? 12'h000 : (k == 15) ? 12'hFFF : 12'((k * 1237 + 19) & 32'hFFF);
        v0 = n_valid;
        run_read(md[1], md[0], code, 10 + k, 1'b1);
        chk(n_valid == v0 + 1, md[1] ? "R6 one valid" : "R5 one valid", n_valid - v0, 1);
        chk(got_res == code, md[1] ? "R6 result" : "R5 result", got_res, code);
        chk(rises == (md[1] ? 16 : 13), md[1] ? "R6 clock count" : "R5 clock count",
            rises, md[1] ? 16 : 13);
        chk(got_ferr == 1'b0, "R7 no framing error", got_ferr, 0);
        chk(min_phase >= HALF, "R4 phase width", min_phase, HALF);
        if (md[0]) begin
          chk(first_rise >= 10 + k, "R3 waits for data rise", first_rise, 10 + k);
          chk(first_rise < CONV_WAIT, "R3 edge ends wait early", first_rise, CONV_WAIT);
        end else begin
          chk(first_rise >= CONV_WAIT, "R2 timed conversion wait", first_rise, CONV_WAIT);
        end
        chk(last_gap >= CS_HIGH_MIN, "R9 cs high gap", last_gap, CS_HIGH_MIN);
      end
    end
    chk(vwide == 0, "R8 valid one cycle", vwide, 0);
    chk(vbad == 0, "R8 cs_n high and sclk low with valid", vbad, 0);

    // framing: byte mode with no leading 1
    run_read(1'b1, 1'b0, 12'h9C3, 5, 1'b0);
    chk(got_ferr == 1'b1, "R7 framing error flagged", got_ferr, 1);
    chk(got_res == 12'h9C3, "R7 result with framing error", got_res, 12'h9C3);
    run_read(1'b0, 1'b0, 12'h3C9, 5, 1'b0);
    chk(got_ferr == 1'b0, "R7 continuous mode no flag", got_ferr, 0);
    chk(got_res == 12'h3C9, "R5 result without leading 1", got_res, 12'h3C9);
    repeat (3) @(negedge clk);
    chk(got_res == 12'h3C9 && result == 12'h3C9, "R8 result held", result, 12'h3C9);

    // edge-detect timeout
    v0 = n_valid; t0 = n_tmo;
    run_read(1'b0, 1'b1, 12'h123, 0, 1'b0);
    chk(n_tmo == t0 + 1, "R3 timeout pulse", n_tmo - t0, 1);
    chk(tmo_gap == EOC_LIMIT, "R3 timeout timing", tmo_gap, EOC_LIMIT);
    chk(n_valid == v0, "R3 no valid on timeout", n_valid - v0, 0);
    chk(rises == 0 && cs_n == 1'b1, "R3 no clocks, cs released", rises, 0);
    run_read(1'b0, 1'b0, 12'h456, 8, 1'b1);
    chk(last_gap >= ACQ_MIN, "R10 gap after timeout", last_gap, ACQ_MIN);
    chk(got_res == 12'h456, "R5 read after timeout", got_res, 12'h456);

    // abort during conversion
    v0 = n_valid;
    @(negedge clk);
    m_eoc = 1'b1; m_delay = 30; m_code = 12'h777; eoc_edge = 1'b1; byte_mode = 1'b0;
    start = 1'b1;
    for (int i = 0; i < 200 && cs_n; i++) @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    @(negedge clk);
    chk(cs_n == 1'b1, "R10 cs raised by abort", cs_n, 1);
    repeat (40) @(negedge clk);
    chk(n_valid == v0 && rises == 0, "R10 no valid after abort", n_valid - v0, 0);
    run_read(1'b1, 1'b1, 12'hABC, 12, 1'b1);
    chk(last_gap >= ACQ_MIN, "R10 gap after abort", last_gap, ACQ_MIN);
    chk(got_res == 12'hABC, "R6 read after abort", got_res, 12'hABC);

    // starts while busy are ignored
    v0 = n_valid; f0 = n_fall;
    @(negedge clk);
    m_eoc = 1'b1; m_delay = 15; m_code = 12'h5A5; eoc_edge = 1'b0; byte_mode = 1'b1;
    start = 1'b1;
    for (int i = 0; i < 200 && cs_n; i++) @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 500 && n_valid == v0; i++) begin
      start = (i % 3 == 0) && busy && !cs_n;
      @(negedge clk);
    end
    start = 1'b0;
    repeat (30) @(negedge clk);
    chk(n_fall == f0 + 1, "R11 single cs_n fall", n_fall - f0, 1);
    chk(n_valid == v0 + 1, "R11 single valid", n_valid - v0, 1);
    chk(got_res == 12'h5A5, "R11 result intact", got_res, 12'h5A5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule